// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from host memory to a byte-stream transmitter. The host places 8-byte descriptors in a circular ring and writes a non-zero value to the kick register to start the engine. The engine then walks the ring from the current index. For every descriptor the host owns, it reads the buffer bytes into a local frame buffer. When a descriptor marks the end of a frame, it streams the assembled frame out.

A frame can span several descriptors. The engine can compute a 16-bit ones'-complement checksum over the tail of the frame and insert it into the frame before the frame leaves. After each descriptor, the engine hands it back to the host by clearing its ownership bit in memory. It also raises sticky completion flags.

The engine has three interfaces: a register write port, one memory port with request/ready handshaking, and a valid/ready byte stream.

Top module: `tx_ring_dma`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: `fo_valid`, `busy`, `ring_idx`, `pend_val`, `st_desc_done` and `st_ring_idle`.
- R2: Register map (`reg_addr`):
  - 0 is kick/pending. Writing a non-zero value starts a ring walk.
  - 1 is the ring register. Bits 31:8 are the base, bits 7:0 are the current index.
  - 2 is the ring size.
  - 3 is transmit configuration. Bit 0 is the enable.
  - 4 is status, write-1-to-clear. Bit 0 is descriptor-done, bit 1 is ring-idle.

  Descriptor i sits at base*256 + 8*i. It holds the status word at offset 0 and the buffer address at offset 4. Status word fields:
  - bit 31: owned by engine
  - bit 30: start of frame
  - bit 29: end of frame
  - bit 28: checksum enable
  - bits 27:20: insert offset
  - bits 19:14: start offset
  - bits 12:0: buffer length
- R3: After each owned descriptor, the index advances by one. It wraps to 0 when it reaches (size+1)*16.
- R4: On a checksum-enabled descriptor, every frame byte at a position at or after the start offset is added to the sum. Bytes at an even distance from the start offset are the high half of a 16-bit word. A start-of-frame descriptor clears the sum and latches both offsets. On an end-of-frame descriptor with checksum enabled, the sum is folded to 16 bits and inverted. Its high byte is written at the insert offset and its low byte at the next position, before emission.
- R5: A frame is the concatenation, in ring order, of the buffer bytes of every descriptor from start-of-frame through end-of-frame. A start-of-frame descriptor restarts assembly at position 0. A zero-length descriptor adds no bytes.
- R6: Each owned descriptor gets its status word written back unchanged except for bit 31, which is cleared.
- R7: Frame bytes leave on `fo_data` under `fo_valid`/`fo_ready`. While the output is stalled, data and `fo_last` hold steady. `fo_last` marks the final byte.
- R8: Each finished descriptor does three things: it sets descriptor-done, clears `pend_val`, and advances the index. Reaching a descriptor that is not owned sets ring-idle and ends the walk without touching the index.
- R9: With transmit enable clear, no frame is emitted. Descriptors are still consumed and written back.
- R10: A frame is capped at 2048 bytes. Buffer bytes past the cap are dropped.
- R11: A memory request stays asserted with a steady address until `mem_ready`. Read data is taken on `mem_rdata` in the cycle after acceptance. A byte read uses bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a 32-bit write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, one cycle after acceptance |
| fo_valid | output | 1 | Frame byte valid |
| fo_data | output | 8 | Frame byte |
| fo_last | output | 1 | Final byte of the frame |
| fo_ready | input | 1 | Consumer takes the byte |
| ring_idx | output | 8 | Current ring index |
| pend_val | output | 32 | Kick/pending register value |
| busy | output | 1 | Walk requested or in progress |
| st_desc_done | output | 1 | Sticky descriptor-done flag |
| st_ring_idle | output | 1 | Sticky ring-idle flag |

## Verification
The engine is tried with several kinds of frame:
- A single-descriptor frame, which shows basic gathering and write-back.
- A three-descriptor frame with odd buffer lengths and checksum insertion. This tells correct start-relative byte pairing apart from pairing per buffer.
- A descriptor at the last ring slot, which separates a correct wrap from an off-by-one count.
- A run with transmit disabled, a 2500-byte input, a zero-length middle descriptor and an initially unowned descriptor. These cover suppression, truncation at the cap, empty buffers and the idle exit.

Stalls on both the memory ready and the stream ready expose any dependence on single-cycle handshakes.

// File: rtl/txr_pkg.sv
// Shared types for the transmit ring engine: descriptor status layout,
// register select codes and controller states.
package txr_pkg;
    localparam int DESC_BYTES = 8;

    typedef struct packed {
        logic        own;
        logic        sop;
        logic        eop;
        logic        ck;
        logic [7:0]  ins;
        logic [5:0]  start;
        logic        spare;
        logic [12:0] len;
    } txr_desc_t;

    localparam logic [2:0] RA_PEND  = 3'd0;
    localparam logic [2:0] RA_RING  = 3'd1;
    localparam logic [2:0] RA_SIZE  = 3'd2;
    localparam logic [2:0] RA_TXCFG = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_ST, S_WT_ST, S_RD_BA, S_WT_BA,
        S_RD_BYTE, S_WT_BYTE, S_POST, S_EMIT, S_WB
    } txr_state_e;
endpackage

// File: rtl/txr_regs.sv
// Register file of the transmit ring engine. Holds kick/pending, ring base
// and index, ring size, transmit enable and sticky status flags.
// Assumes engine updates arrive as single-cycle strobes; an engine update
// overrides a host write in the same cycle.
module txr_regs
    import txr_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              go_take,
    input  logic              idx_load,
    input  logic [IDX_W-1:0]  idx_next,
    input  logic              set_desc,
    input  logic              set_idle,
    output logic              go_q,
    output logic [31:0]       pend_q,
    output logic [31-IDX_W:0] base_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic [SIZE_W-1:0] size_q,
    output logic              tx_en_q,
    output logic              st_desc_q,
    output logic              st_idle_q
);
    // Host writes first, engine strobes last so that they take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q      <= 1'b0;
            pend_q    <= '0;
            base_q    <= '0;
            idx_q     <= '0;
            size_q    <= '0;
            tx_en_q   <= 1'b0;
            st_desc_q <= 1'b0;
            st_idle_q <= 1'b0;
        end else begin
            if (go_take) go_q <= 1'b0;
            if (reg_we) begin
                case (reg_addr)
                    RA_PEND: begin
                        pend_q <= reg_wdata;
                        if (reg_wdata != '0) go_q <= 1'b1;
                    end
                    RA_RING: begin
                        base_q <= reg_wdata[31:IDX_W];
                        idx_q  <= reg_wdata[IDX_W-1:0];
                    end
                    RA_SIZE:  size_q  <= reg_wdata[SIZE_W-1:0];
                    RA_TXCFG: tx_en_q <= reg_wdata[0];
                    RA_STAT: begin
                        if (reg_wdata[0]) st_desc_q <= 1'b0;
                        if (reg_wdata[1]) st_idle_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (idx_load) begin
                idx_q  <= idx_next;
                pend_q <= '0;
            end
            if (set_desc) st_desc_q <= 1'b1;
            if (set_idle) st_idle_q <= 1'b1;
        end
    end
endmodule

// File: rtl/txr_csum.sv
// Ones'-complement checksum accumulator. Adds one byte per strobe as either
// the high or low half of a 16-bit word and presents the folded, inverted
// result. Assumes fewer than 65536 bytes per frame, so 32 bits cannot overflow.
module txr_csum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        add_en,
    input  logic [7:0]  add_byte,
    input  logic        odd,
    output logic [15:0] csum
);
    logic [31:0] acc_q;
    logic [16:0] f1;
    logic [15:0] f2;

    // Accumulate bytes; clear at start of frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (add_en)   acc_q <= acc_q + (odd ? {24'd0, add_byte} : {16'd0, add_byte, 8'd0});
    end

    // Fold twice into 16 bits and invert.
    always_comb begin
        f1   = {1'b0, acc_q[15:0]} + {1'b0, acc_q[31:16]};
        f2   = f1[15:0] + {15'd0, f1[16]};
        csum = ~f2;
    end
endmodule

// File: rtl/txr_fbuf.sv
// Local frame buffer. One byte write port for gathering and a two-byte
// write port for checksum insertion, plus an asynchronous read port.
// Assumes the insert offset plus one stays below DEPTH.
module txr_fbuf #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          ins_en,
    input  logic [7:0]    ins_addr,
    input  logic [15:0]   ins_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    // Store gathered bytes and the big-endian checksum.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (ins_en) begin
            mem[AW'(ins_addr)]        <= ins_data[15:8];
            mem[AW'(ins_addr) + AW'(1)] <= ins_data[7:0];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tx_ring_dma.sv
// Transmit descriptor ring engine. A kick write starts a walk. Each owned
// descriptor's buffer is gathered byte by byte into the frame buffer. At end
// of frame the checksum is optionally inserted and the frame is streamed out.
// The status is then written back with ownership cleared. Assumes memory read
// data arrives the cycle after an accepted request.
module tx_ring_dma
    import txr_pkg::*;
#(
    parameter int FRAME_MAX = 2048,
    parameter int IDX_W     = 8,
    parameter int SIZE_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ready,
    input  logic [31:0]      mem_rdata,
    output logic             fo_valid,
    output logic [7:0]       fo_data,
    output logic             fo_last,
    input  logic             fo_ready,
    output logic [IDX_W-1:0] ring_idx,
    output logic [31:0]      pend_val,
    output logic             busy,
    output logic             st_desc_done,
    output logic             st_ring_idle
);
    localparam int POS_W = $clog2(FRAME_MAX + 1);
    localparam int FB_AW = $clog2(FRAME_MAX);
    localparam int LEN_W = 13;
    localparam int CMP_W = ((POS_W > LEN_W) ? POS_W : LEN_W) + 1;
    localparam int CNT_W = SIZE_W + 5;

    txr_state_e        state_q;
    txr_desc_t         st_q;
    logic [31:0]       buf_q;
    logic [LEN_W-1:0]  cnt_q, eff_q, eff_c;
    logic [POS_W-1:0]  pos_q;
    logic [5:0]        start_q;
    logic [7:0]        ins_q;
    logic [FB_AW-1:0]  oidx_q;
    logic              go_q, tx_en_q;
    logic [31-IDX_W:0] base_q;
    logic [SIZE_W-1:0] size_q;
    logic [IDX_W:0]    inc_c;
    logic [IDX_W-1:0]  idx_next;
    logic [31:0]       desc_addr;
    logic [CMP_W-1:0]  room_c, len_c;
    logic [15:0]       csum;
    logic              is_last, wb_done, go_take, set_idle;

    txr_regs #(.IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_regs (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
        .go_take, .idx_load(wb_done), .idx_next, .set_desc(wb_done), .set_idle,
        .go_q, .pend_q(pend_val), .base_q, .idx_q(ring_idx), .size_q, .tx_en_q,
        .st_desc_q(st_desc_done), .st_idle_q(st_ring_idle)
    );

    txr_csum u_csum (
        .clk, .rst_n,
        .clr(state_q == S_WT_ST && mem_rdata[31] && mem_rdata[30]),
        .add_en(state_q == S_WT_BYTE && st_q.ck && pos_q >= POS_W'(start_q)),
        .add_byte(mem_rdata[7:0]),
        .odd(pos_q[0] ^ start_q[0]),
        .csum
    );

    txr_fbuf #(.DEPTH(FRAME_MAX)) u_fbuf (
        .clk,
        .wr_en(state_q == S_WT_BYTE), .wr_addr(pos_q[FB_AW-1:0]), .wr_data(mem_rdata[7:0]),
        .ins_en(state_q == S_POST && st_q.eop && st_q.ck), .ins_addr(ins_q), .ins_data(csum),
        .rd_addr(oidx_q), .rd_data(fo_data)
    );

    // Derived addresses, wrap index, truncated length and stream flags.
    always_comb begin
        desc_addr = {base_q, {IDX_W{1'b0}}} + 32'({ring_idx, 3'b000});
        inc_c     = (IDX_W+1)'(ring_idx) + (IDX_W+1)'(1);
        idx_next  = (CNT_W'(inc_c) >= CNT_W'({size_q, 4'b0000}) + CNT_W'(16)) ? '0 : inc_c[IDX_W-1:0];
        room_c    = CMP_W'(FRAME_MAX) - CMP_W'(pos_q);
        len_c     = CMP_W'(st_q.len);
        eff_c     = LEN_W'((len_c > room_c) ? room_c : len_c);
        is_last   = (POS_W'(oidx_q) + POS_W'(1)) == pos_q;
        wb_done   = state_q == S_WB && mem_ready;
        go_take   = state_q == S_IDLE && go_q;
        set_idle  = state_q == S_WT_ST && !mem_rdata[31];
        busy      = state_q != S_IDLE || go_q;
        fo_valid  = state_q == S_EMIT;
        fo_last   = fo_valid && is_last;
        mem_we    = state_q == S_WB;
        mem_req   = state_q inside {S_RD_ST, S_RD_BA, S_RD_BYTE, S_WB};
        mem_wdata = {1'b0, st_q[30:0]};
        case (state_q)
            S_RD_BA:   mem_addr = desc_addr + 32'd4;
            S_RD_BYTE: mem_addr = buf_q + 32'(cnt_q);
            default:   mem_addr = desc_addr;
        endcase
    end

    // Walk controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            st_q    <= '0;
            buf_q   <= '0;
            cnt_q   <= '0;
            eff_q   <= '0;
            pos_q   <= '0;
            start_q <= '0;
            ins_q   <= '0;
            oidx_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE:  if (go_q) state_q <= S_RD_ST;
                S_RD_ST: if (mem_ready) state_q <= S_WT_ST;
                S_WT_ST: begin
                    st_q <= mem_rdata;
                    if (!mem_rdata[31]) state_q <= S_IDLE;
                    else begin
                        if (mem_rdata[30]) begin
                            pos_q   <= '0;
                            start_q <= mem_rdata[19:14];
                            ins_q   <= mem_rdata[27:20];
                        end
                        state_q <= S_RD_BA;
                    end
                end
                S_RD_BA: if (mem_ready) state_q <= S_WT_BA;
                S_WT_BA: begin
                    buf_q   <= mem_rdata;
                    eff_q   <= eff_c;
                    cnt_q   <= '0;
                    state_q <= (eff_c == '0) ? S_POST : S_RD_BYTE;
                end
                S_RD_BYTE: if (mem_ready) state_q <= S_WT_BYTE;
                S_WT_BYTE: begin
                    pos_q   <= pos_q + POS_W'(1);
                    cnt_q   <= cnt_q + LEN_W'(1);
                    state_q <= (cnt_q + LEN_W'(1) == eff_q) ? S_POST : S_RD_BYTE;
                end
                S_POST: begin
                    oidx_q  <= '0;
                    state_q <= (st_q.eop && tx_en_q && pos_q != '0) ? S_EMIT : S_WB;
                end
                S_EMIT: if (fo_ready) begin
                    if (is_last) state_q <= S_WB;
                    else oidx_q <= oidx_q + FB_AW'(1);
                end
                S_WB: if (mem_ready) begin
                    if (st_q.eop) pos_q <= '0;
                    state_q <= S_RD_ST;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txr_chk.sv
// Protocol checker for the transmit ring engine, bound to the top module.
module txr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fo_valid,
    input logic        fo_ready,
    input logic [7:0]  fo_data,
    input logic        fo_last,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        tx_en
);
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fo_last |-> fo_valid); // R7
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fo_valid && !fo_ready |=> fo_valid && $stable(fo_data) && $stable(fo_last)); // R7
    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        fo_valid && fo_ready && fo_last |=> !fo_valid); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
    AST_WB_NOT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]); // R6
    AST_EMIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fo_valid) |-> tx_en); // R9
endmodule

bind tx_ring_dma txr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fo_valid(fo_valid), .fo_ready(fo_ready),
    .fo_data(fo_data), .fo_last(fo_last), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tx_en(tx_en_q)
);

// File: tb/tx_ring_dma_bench.sv
module tx_ring_dma_bench;
    localparam int BASE = 32'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we, mem_ready = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        fo_valid, fo_last, fo_ready = 1'b1;
    logic [7:0]  fo_data;
    logic [7:0]  ring_idx;
    logic [31:0] pend_val;
    logic        busy, st_desc_done, st_ring_idle;

    int checks = 0, failures = 0, emitted = 0, cyc = 0;
    bit stall_on = 0, done = 0;
    logic [7:0] mem [0:65535];
    int exp_q[$];

    tx_ring_dma u_tx_ring_dma (.*);

    always #4 clk = ~clk;

    // Memory model: accepted request, data on the next cycle.
    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            int a;
            a = int'(mem_addr[15:0]);
            if (mem_we) begin
                for (int k = 0; k < 4; k++) mem[(a + k) & 16'hffff] = mem_wdata[8*k +: 8];
            end else begin
                for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] <= mem[(a + k) & 16'hffff];
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive handshakes and compare the stream against the model on every clock.
    always @(negedge clk) begin
        cyc++;
        mem_ready = stall_on ? (cyc % 5 != 3) : 1'b1;
        fo_ready  = stall_on ? (cyc % 4 != 2) : 1'b1;
        if (rst_n && fo_valid && fo_ready) begin
            emitted++;
            if (exp_q.size() == 0) chk(0, "R9 unexpected byte", int'(fo_data), -1);
            else begin
                int e;
                e = exp_q.pop_front();
                chk({fo_last, fo_data} == 9'(e), "R5/R7 stream byte", int'({fo_last, fo_data}), e);
            end
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] get_word(int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic set_desc(int i, logic [31:0] st, logic [31:0] ba);
        for (int k = 0; k < 4; k++) begin
            mem[BASE + 8*i + k]     = st[8*k +: 8];
            mem[BASE + 8*i + 4 + k] = ba[8*k +: 8];
        end
    endtask

    function automatic logic [31:0] mk(bit sop, bit eop, bit ck, int ins, int st, int len);
        return {1'b1, sop, eop, ck, 8'(ins), 6'(st), 1'b0, 13'(len)};
    endfunction

    task automatic add_bytes(ref int fr[$], input int ba, input int len);
        for (int k = 0; k < len && fr.size() < 2048; k++) fr.push_back(int'(mem[(ba + k) & 16'hffff]));
    endtask

    task automatic push_frame(int fr[$]);
        foreach (fr[k]) exp_q.push_back(((k == fr.size() - 1) ? 256 : 0) + fr[k]);
    endtask

    task automatic kick_and_wait();
        wr(3'd0, 32'd1);
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int fr[$];
        int sum, cs, e0;
        for (int a = 0; a < 65536; a++) mem[a] = 8'((a * 7 + 3) ^ (a >> 8));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fo_valid == 0 && busy == 0, "R1 valid/busy", int'({fo_valid, busy}), 0);
        chk(ring_idx == 0 && pend_val == 0, "R1 idx/pend", int'(ring_idx), 0);
        chk(st_desc_done == 0 && st_ring_idle == 0, "R1 status", int'({st_desc_done, st_ring_idle}), 0);

        wr(3'd1, BASE); wr(3'd2, 0); wr(3'd3, 1);

        // R2 single descriptor frame
        set_desc(0, mk(1, 1, 0, 0, 0, 5), 32'h4000);
        set_desc(1, 32'h0, 32'h0);
        fr = {}; add_bytes(fr, 32'h4000, 5); push_frame(fr);
        kick_and_wait();
        chk(exp_q.size() == 0, "R2 frame delivered", exp_q.size(), 0);
        chk(ring_idx == 1, "R3 index advance", int'(ring_idx), 1);
        chk(get_word(BASE) == (mk(1, 1, 0, 0, 0, 5) & 32'h7fffffff), "R6 writeback",
            int'(get_word(BASE)), int'(mk(1, 1, 0, 0, 0, 5) & 32'h7fffffff));
        chk(st_desc_done && st_ring_idle && pend_val == 0, "R8 status after walk",
            int'({st_desc_done, st_ring_idle, pend_val != 0}), 6);
        wr(3'd4, 3);
        chk(!st_desc_done && !st_ring_idle, "R8 clear", int'({st_desc_done, st_ring_idle}), 0);

        // R4 three-descriptor frame with checksum, stalls on both handshakes
        stall_on = 1;
        set_desc(1, mk(1, 0, 1, 10, 2, 3), 32'h5001);
        set_desc(2, mk(0, 0, 1, 0, 0, 4), 32'h5103);
        set_desc(3, mk(0, 1, 1, 0, 0, 5), 32'h5200);
        set_desc(4, 32'h0, 32'h0);
        fr = {}; add_bytes(fr, 32'h5001, 3); add_bytes(fr, 32'h5103, 4); add_bytes(fr, 32'h5200, 5);
        sum = 0;
        for (int p = 2; p < 12; p++) sum += ((p - 2) % 2 == 0) ? fr[p] * 256 : fr[p];
        while (sum > 32'hffff) sum = (sum & 32'hffff) + (sum >> 16);
        cs = (~sum) & 32'hffff;
        fr[10] = cs >> 8; fr[11] = cs & 255;
        push_frame(fr);
        kick_and_wait();
        stall_on = 0;
        chk(exp_q.size() == 0, "R4 checksum frame delivered", exp_q.size(), 0);
        chk(ring_idx == 4, "R5 multi-descriptor index", int'(ring_idx), 4);

        // R3 wrap at (size+1)*16
        wr(3'd1, BASE | 15);
        set_desc(15, mk(1, 1, 0, 0, 0, 2), 32'h6000);
        fr = {}; add_bytes(fr, 32'h6000, 2); push_frame(fr);
        kick_and_wait();
        chk(ring_idx == 0, "R3 wrap", int'(ring_idx), 0);

        // R9 transmit disabled: no bytes, descriptor still consumed
        wr(3'd3, 0);
        set_desc(0, mk(1, 1, 0, 0, 0, 4), 32'h6100);
        e0 = emitted;
        kick_and_wait();
        chk(emitted == e0, "R9 no emission", emitted - e0, 0);
        chk(ring_idx == 1 && !mem[BASE + 3][7], "R9 consumed", int'(ring_idx), 1);

        // R10 truncation at 2048
        wr(3'd3, 1);
        set_desc(1, mk(1, 0, 0, 0, 0, 1500), 32'h4000);
        set_desc(2, mk(0, 1, 0, 0, 0, 1000), 32'h8000);
        set_desc(3, 32'h0, 32'h0);
        fr = {}; add_bytes(fr, 32'h4000, 1500); add_bytes(fr, 32'h8000, 1000);
        chk(fr.size() == 2048, "R10 model length", fr.size(), 2048);
        push_frame(fr);
        kick_and_wait();
        chk(exp_q.size() == 0, "R10 truncated frame delivered", exp_q.size(), 0);

        // R8 unowned descriptor: idle set, nothing else moves
        wr(3'd4, 3);
        kick_and_wait();
        chk(st_ring_idle && !st_desc_done, "R8 idle only", int'({st_desc_done, st_ring_idle}), 1);
        chk(ring_idx == 3 && pend_val == 1, "R8 index/pending kept", int'(ring_idx), 3);

        // R5 zero-length middle descriptor
        set_desc(3, mk(1, 0, 0, 0, 0, 2), 32'h7000);
        set_desc(4, mk(0, 0, 0, 0, 0, 0), 32'h7100);
        set_desc(5, mk(0, 1, 0, 0, 0, 1), 32'h7200);
        set_desc(6, 32'h0, 32'h0);
        fr = {}; add_bytes(fr, 32'h7000, 2); add_bytes(fr, 32'h7200, 1); push_frame(fr);
        kick_and_wait();
        chk(exp_q.size() == 0, "R5 zero-length frame delivered", exp_q.size(), 0);
        chk(ring_idx == 6, "R5 zero-length index", int'(ring_idx), 6);
        chk(!mem[BASE + 8*4 + 3][7], "R6 zero-length writeback", int'(mem[BASE + 35]), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule